// File: doc/BRIEF.md
# Column Median Engine with Folded Ping-Pong Histograms

This block finds the median grey level of each image column while the pixels stream in. The pixels of one column arrive one per cycle. Only those that fall inside a marked span are counted. A column is framed by a start strobe and an end strobe, and the next column may follow immediately. While the current column fills one histogram bank, the median of the previous column is searched in the other bank. The two banks trade roles at every column end.

Each histogram word holds two counters. One counter is for a low grey level. The other is for its mirror level in the upper half of the range, where all the low bits are inverted. The search reads one word per cycle from address 0 upward. In doing so it walks the lower half of the range upward and the upper half downward at the same time, which covers two bins every cycle. Each visited word is written back as zero, so the bank is clean for reuse when its next turn to accumulate arrives. A full sweep of a bank fits comfortably inside a 160-pixel column period.

The pixel input has no back-pressure: a pixel is taken on every cycle in which it is marked valid. The result strobe cannot be stalled either. It is a one-cycle pulse, and the consumer must capture it.

Top module: `column_median`

## Requirements
- R1: After reset, med_valid is 0 and med_value is 0. Every histogram counter starts at zero, so the first column's result depends only on its own pixels.
- R2: A pixel is counted only when pix_valid and pix_in_span are both 1 and the column window is open. The window opens in the cycle where col_start is 1, and that cycle's pixel counts. It stays open up to and including the cycle where col_end is 1. Pixels outside the window are ignored.
- R3: With n counted pixels, let T = ceil(n/2). For a = 0..127, L(a) is the count of levels 0..a and H(a) is the count of levels 255-a..255. The result is decided at the first a where either L(a) >= T or H(a) >= T. If L(a) >= T, the result is a. Otherwise the result is 255-a. The low side wins when both reach T at the same a. For odd n this is the exact median.
- R4: A column with no counted pixels produces a result of 0, with a valid strobe.
- R5: Each column end produces exactly one med_valid pulse. The pulse comes between 1 and 131 cycles after the clock edge that samples col_end. Results appear in column order.
- R6: The column being accumulated and the column being searched use different banks. The pixels of one column never change the result of a neighbouring column.
- R7: The search leaves every word of the searched bank at zero. A column's counts do not leak into the column two places later, which reuses the same bank.
- R8: Counted pixels on consecutive cycles that hit the same histogram word are all counted. This holds for repeats of one level and for alternation between a level and its mirror (for example 1 and 254, which share word 1).
- R9: A column may hold up to 255 counted pixels. Successive col_end strobes must be at least 131 cycles apart.
- R10: Levels 128..255 are counted in the upper counter of word (255 - level). For example, level 255 is in word 0 and level 129 is in word 126. Results in the upper half come out as 255-a.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| col_start | input | 1 | First cycle of a column; opens the window and clears the tally |
| col_end | input | 1 | Last cycle of a column; swaps banks and starts the search |
| pix_valid | input | 1 | A pixel is present this cycle |
| pix_in_span | input | 1 | The present pixel lies within the marked span |
| pix_data | input | 8 | Grey level |
| med_valid | output | 1 | One-cycle pulse when a column result is ready |
| med_value | output | 8 | Median grey level of the column |

## Verification
The bench targets the tie case where L and H reach T at the same address (alternating 0 and 255): a design that lets the high side win would report 255 instead of 0. It also targets back-to-back hits on one word, including mirror pairs, where missing forwarding would lose counts and shift the median. It runs a large single-level column followed by a tiny one in the same bank; a sweep that fails to clear would report the old level. Empty and single-pixel columns, junk pixels outside the window and random spans check that the window, the tally and the result-per-column rule all hold.

// File: rtl/colmed_pkg.sv
package colmed_pkg;
  localparam int unsigned DEF_PIX_W = 8;
  localparam int unsigned DEF_CNT_W = 8;

  typedef enum logic [1:0] {
    SW_IDLE,
    SW_ARM,
    SW_SCAN,
    SW_DRAIN
  } sweep_state_e;
endpackage

// File: rtl/colmed_framer.sv
module colmed_framer #(
  parameter int unsigned CNT_W = colmed_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             col_start,
  input  logic             col_end,
  input  logic             pix_valid,
  input  logic             pix_in_span,
  output logic             accept,
  output logic [CNT_W-1:0] total
);
  logic             open_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] base;
  logic             window;

  always_comb begin
    window = open_q | col_start;
    accept = pix_valid & pix_in_span & window;
    base   = col_start ? '0 : cnt_q;
    total  = base + CNT_W'(accept);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (col_end)        open_q <= 1'b0;
      else if (col_start) open_q <= 1'b1;
      cnt_q <= total;
    end
  end

  // R9: the tally never wraps within a column
  p_tally_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (base != '1));
endmodule

// File: rtl/colmed_bank.sv
module colmed_bank #(
  parameter int unsigned PIX_W = colmed_pkg::DEF_PIX_W,
  parameter int unsigned CNT_W = colmed_pkg::DEF_CNT_W,
  localparam int unsigned AW    = PIX_W - 1,
  localparam int unsigned WORDS = 1 << AW,
  localparam int unsigned DW    = 2 * CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_en,
  input  logic [AW-1:0] inc_addr,
  input  logic          inc_hi,
  input  logic          swp_en,
  input  logic [AW-1:0] swp_addr,
  output logic [DW-1:0] swp_data
);
  logic [DW-1:0] mem [WORDS];

  logic          s1_v;
  logic [AW-1:0] s1_addr;
  logic          s1_hi;
  logic [DW-1:0] s1_word;
  logic [DW-1:0] s1_new;
  logic          fwd;

  always_comb begin
    if (s1_hi) s1_new = {s1_word[DW-1:CNT_W] + CNT_W'(1), s1_word[CNT_W-1:0]};
    else       s1_new = {s1_word[DW-1:CNT_W], s1_word[CNT_W-1:0] + CNT_W'(1)};
    fwd = inc_en && s1_v && (inc_addr == s1_addr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(WORDS); i++) mem[i] <= '0;
      s1_v     <= 1'b0;
      s1_addr  <= '0;
      s1_hi    <= 1'b0;
      s1_word  <= '0;
      swp_data <= '0;
    end else begin
      s1_v <= inc_en;
      if (inc_en) begin
        s1_addr <= inc_addr;
        s1_hi   <= inc_hi;
        s1_word <= fwd ? s1_new : mem[inc_addr];
      end
      if (s1_v)        mem[s1_addr]  <= s1_new;
      else if (swp_en) mem[swp_addr] <= '0;
      if (swp_en) swp_data <= mem[swp_addr];
    end
  end

  // R6: a bank is never accumulated and swept in the same cycle
  p_port_clash_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v || inc_en) |-> !swp_en);

  // R9: a bin counter never wraps
  p_bin_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v |-> ((s1_hi ? s1_word[DW-1:CNT_W] : s1_word[CNT_W-1:0]) != '1));
endmodule

// File: rtl/colmed_sweep.sv
module colmed_sweep #(
  parameter int unsigned PIX_W = colmed_pkg::DEF_PIX_W,
  parameter int unsigned CNT_W = colmed_pkg::DEF_CNT_W,
  localparam int unsigned AW = PIX_W - 1,
  localparam int unsigned DW = 2 * CNT_W,
  localparam int unsigned SW = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] total,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr,
  input  logic [DW-1:0]    rd_data,
  output logic             busy,
  output logic             med_valid,
  output logic [PIX_W-1:0] med_value
);
  import colmed_pkg::*;

  sweep_state_e  state;
  logic [AW-1:0] addr_q;
  logic          dv_q;
  logic [AW-1:0] daddr_q;
  logic [SW-1:0] thr_q;
  logic [SW-1:0] lo_sum, hi_sum, lo_new, hi_new;
  logic          found_q;

  always_comb begin
    rd_en   = (state == SW_SCAN);
    rd_addr = addr_q;
    busy    = (state != SW_IDLE);
    lo_new  = lo_sum + SW'(rd_data[CNT_W-1:0]);
    hi_new  = hi_sum + SW'(rd_data[DW-1:CNT_W]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SW_IDLE;
      addr_q    <= '0;
      dv_q      <= 1'b0;
      daddr_q   <= '0;
      thr_q     <= '0;
      lo_sum    <= '0;
      hi_sum    <= '0;
      found_q   <= 1'b0;
      med_valid <= 1'b0;
      med_value <= '0;
    end else begin
      med_valid <= 1'b0;
      dv_q      <= rd_en;
      daddr_q   <= addr_q;
      unique case (state)
        SW_IDLE: if (start) begin
          state   <= SW_ARM;
          thr_q   <= (SW'(total) + SW'(1)) >> 1;
          lo_sum  <= '0;
          hi_sum  <= '0;
          found_q <= 1'b0;
        end
        SW_ARM: begin
          state  <= SW_SCAN;
          addr_q <= '0;
        end
        SW_SCAN: begin
          addr_q <= addr_q + AW'(1);
          if (addr_q == '1) state <= SW_DRAIN;
        end
        SW_DRAIN: state <= SW_IDLE;
        default:  state <= SW_IDLE;
      endcase
      if (dv_q) begin
        lo_sum <= lo_new;
        hi_sum <= hi_new;
        if (!found_q) begin
          if (lo_new >= thr_q) begin
            found_q   <= 1'b1;
            med_valid <= 1'b1;
            med_value <= {1'b0, daddr_q};
          end else if (hi_new >= thr_q) begin
            found_q   <= 1'b1;
            med_valid <= 1'b1;
            med_value <= {1'b1, ~daddr_q};
          end
        end
      end
    end
  end

  // R9: a new column end only arrives once the previous sweep is over
  p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (state == SW_IDLE));

  // R3: every sweep reaches the threshold before it ends
  p_found_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SW_DRAIN) |=> found_q);

  // R5: the result strobe is a single-cycle pulse
  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    med_valid |=> !med_valid);
endmodule

// File: rtl/column_median.sv
module column_median #(
  parameter int unsigned PIX_W = colmed_pkg::DEF_PIX_W,
  parameter int unsigned CNT_W = colmed_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             col_start,
  input  logic             col_end,
  input  logic             pix_valid,
  input  logic             pix_in_span,
  input  logic [PIX_W-1:0] pix_data,
  output logic             med_valid,
  output logic [PIX_W-1:0] med_value
);
  localparam int unsigned AW = PIX_W - 1;
  localparam int unsigned DW = 2 * CNT_W;

  logic             accept;
  logic [CNT_W-1:0] total;
  logic             bank_sel_q;
  logic [AW-1:0]    inc_addr;
  logic             inc_hi;
  logic             rd_en;
  logic [AW-1:0]    rd_addr;
  logic [DW-1:0]    rd_data;
  logic             sweep_busy;
  logic [DW-1:0]    bank_data [2];

  always_comb begin
    inc_hi   = pix_data[PIX_W-1];
    inc_addr = inc_hi ? ~pix_data[AW-1:0] : pix_data[AW-1:0];
    rd_data  = bank_sel_q ? bank_data[0] : bank_data[1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       bank_sel_q <= 1'b0;
    else if (col_end) bank_sel_q <= ~bank_sel_q;
  end

  colmed_framer #(.CNT_W(CNT_W)) u_framer (
    .clk         (clk),
    .rst_n       (rst_n),
    .col_start   (col_start),
    .col_end     (col_end),
    .pix_valid   (pix_valid),
    .pix_in_span (pix_in_span),
    .accept      (accept),
    .total       (total)
  );

  for (genvar g = 0; g < 2; g++) begin : g_bank
    colmed_bank #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc_en   (accept && (bank_sel_q == 1'(g))),
      .inc_addr (inc_addr),
      .inc_hi   (inc_hi),
      .swp_en   (rd_en && (bank_sel_q != 1'(g))),
      .swp_addr (rd_addr),
      .swp_data (bank_data[g])
    );
  end

  colmed_sweep #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_sweep (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (col_end),
    .total     (total),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .busy      (sweep_busy),
    .med_valid (med_valid),
    .med_value (med_value)
  );

  // R5: a result only emerges while a sweep is in progress
  p_valid_in_sweep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    med_valid |-> $past(sweep_busy));

  // R9: column ends respect the minimum spacing
  p_col_spacing_r9: assert property (@(posedge clk) disable iff (!rst_n)
    col_end |-> !sweep_busy);
endmodule

// File: tb/column_median_tb.sv
module column_median_tb;
  localparam int COL_CYC = 160;
  localparam int MAX_LAT = 131;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       col_start = 1'b0, col_end = 1'b0;
  logic       pix_valid = 1'b0, pix_in_span = 1'b0;
  logic [7:0] pix_data = '0;
  logic       med_valid;
  logic [7:0] med_value;

  int    checks = 0, fails = 0, cyc = 0;
  int    hist [256];
  int    exp_med [128];
  int    end_cyc [128];
  string exp_req [128];
  int    wr_idx = 0, rd_idx = 0;
  bit    finished = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  column_median u_dut (
    .clk(clk), .rst_n(rst_n), .col_start(col_start), .col_end(col_end),
    .pix_valid(pix_valid), .pix_in_span(pix_in_span), .pix_data(pix_data),
    .med_valid(med_valid), .med_value(med_value)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int med_model(input int n);
    int t, lo, hi;
    t = (n + 1) / 2; lo = 0; hi = 0;
    for (int a = 0; a < 128; a++) begin
      lo += hist[a];
      hi += hist[255 - a];
      if (lo >= t) return a;
      if (hi >= t) return 255 - a;
    end
    return 0;
  endfunction

  always @(negedge clk) begin
    if (rst_n && med_valid) begin
      if (rd_idx >= wr_idx) begin
        check(1'b0, "R5", rd_idx + 1, wr_idx);
      end else begin
        check(int'(med_value) == exp_med[rd_idx], exp_req[rd_idx], med_value, exp_med[rd_idx]);
        check((cyc - end_cyc[rd_idx]) >= 1 && (cyc - end_cyc[rd_idx]) <= MAX_LAT,
              "R5", cyc - end_cyc[rd_idx], MAX_LAT);
        rd_idx++;
      end
    end
  end

  // mode 0 constant a, 1 nothing in span, 2 alternate a/b, 3 random, 4 narrow runs near a
  task automatic run_col(input int len, input int mode, input int a, input int b, input string req);
    int n, k;
    bit in_col, v, s;
    int d;
    for (int i = 0; i < 256; i++) hist[i] = 0;
    n = 0;
    for (int i = 0; i < COL_CYC; i++) begin
      @(negedge clk);
      in_col = (i >= COL_CYC - len);
      k = i - (COL_CYC - len);
      v = 1'b1; s = 1'b1; d = int'($urandom % 256);
      if (in_col) begin
        case (mode)
          0: d = a;
          1: s = 1'b0;
          2: d = (k % 2 == 1) ? b : a;
          3: begin v = ($urandom % 4) != 0; s = ($urandom % 4) != 0; end
          default: begin s = ($urandom % 8) != 0; d = (a + int'($urandom % 4)) % 256; end
        endcase
      end
      col_start   = in_col && (k == 0);
      col_end     = (i == COL_CYC - 1);
      pix_valid   = v;
      pix_in_span = s;
      pix_data    = 8'(d);
      if (in_col && v && s) begin hist[d]++; n++; end
    end
    exp_med[wr_idx] = med_model(n);
    exp_req[wr_idx] = req;
    end_cyc[wr_idx] = cyc;
    wr_idx++;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    check(med_valid == 1'b0, "R1", med_valid, 0);
    check(med_value == 8'd0, "R1", med_value, 0);
    rst_n = 1'b1;
    run_col(160, 0, 200, 0, "R9");     // full-capacity single level
    run_col(60, 1, 0, 0, "R4");        // empty column
    run_col(5, 0, 10, 0, "R7");        // same bank as the 200 column
    run_col(40, 0, 255, 0, "R10");     // top level, word 0 upper half
    run_col(20, 2, 0, 255, "R3");      // tie at address 0, low wins -> 0
    run_col(11, 2, 255, 0, "R10");     // 6x255, 5x0 -> 255
    run_col(1, 0, 129, 0, "R9");       // start and end in one cycle
    run_col(9, 2, 1, 254, "R8");       // mirror pair in word 1 -> 1
    run_col(50, 0, 77, 0, "R2");       // junk outside the window
    for (int c = 0; c < 12; c++) run_col(1 + int'($urandom % 160), 3, 0, 0, "R6");
    for (int c = 0; c < 8; c++) run_col(80 + int'($urandom % 81), 4, int'($urandom % 256), 0, "R8");
    @(negedge clk);
    col_end = 1'b0; col_start = 1'b0; pix_valid = 1'b0; pix_in_span = 1'b0;
    repeat (200) @(negedge clk);
    check(rd_idx == wr_idx, "R5", rd_idx, wr_idx);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R5 watchdog actual=%0d expected=%0d", rd_idx, wr_idx);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule